// File: doc/BRIEF.md
# Offset, Gain and Shift Correction Pipeline

This block corrects a raw signed sample coming out of a decimation filter. A signed offset is added to the sample first. The sum is then multiplied by an unsigned gain. The product is shifted arithmetically to the right, and the result is clamped to a 24-bit signed word. Samples enter and leave on valid/ready streams, and the work takes two register stages.

The correction constants sit in three internal registers. A single-cycle load strobe writes all three at once. Reset gives a gain of one, a zero offset and a zero shift, so after reset the block passes data through unchanged.

Each stage holds a sample until the next stage or the consumer takes it. A sample moves on only when `out_ready` is high or the slot ahead of it is empty. `in_ready` is high whenever stage one can accept a sample in this cycle. With `out_ready` held high the block accepts one sample per cycle. The consumer may drop `out_ready` at any time: the output then holds its value, and the block fills no more than its two stages before it lowers `in_ready`.

Top module: `offset_gain_corr`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high. The correction registers hold gain 1, offset 0 and shift 0, so a sample leaves the block with its value unchanged.
- R2: For a sample x with offset O, gain G and shift S, the output is floor((x + O) × G / 2^S), clamped as in R7.
- R3: The offset is a signed two's-complement value and is added to the sample before the gain multiplies it.
- R4: The gain is a 16-bit unsigned number. 0xFFFF multiplies by 65535, and a gain of 0 gives an output of 0.
- R5: The right shift is arithmetic and rounds toward negative infinity. For example, -3 shifted by 1 gives -2, and -3000 shifted by 4 gives -188.
- R6: The shift field is 8 bits wide. Any value from 31 to 255 acts as a shift of 31.
- R7: A corrected value above 8388607 is output as 8388607. A value below -8388608 is output as -8388608. The sum and the product are held wide enough that nothing wraps before this clamp.
- R8: While `out_ready` stays high, a sample accepted at a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high exactly two edges later.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. Stage one can still take one more sample; after that, `in_ready` is low. No sample is lost or duplicated when `out_ready` returns high. `in_ready` is always high while `out_valid` is low.
- R10: When `cfg_load` is high at a clock edge, the three registers take the values on the `cfg_*` inputs. A sample accepted at that same edge or earlier is corrected with the old values. Samples accepted at later edges use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Loads the three correction registers at this edge |
| cfg_offset | input | 24 | Signed offset value to load |
| cfg_gain | input | 16 | Unsigned gain value to load |
| cfg_shift | input | 8 | Right-shift amount to load |
| in_valid | input | 1 | Raw sample present on `in_data` |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | 24 | Raw signed sample |
| out_valid | output | 1 | Corrected sample present on `out_data` |
| out_ready | input | 1 | Consumer takes the sample this cycle |
| out_data | output | 24 | Corrected, clamped signed sample |

## Verification
Each fault shows up at the ports within two edges of the sample it touches.
- A wrong sum or product width appears as a wrapped value where a clamped rail is expected.
- A logical shift in place of an arithmetic one appears as a large positive value for a negative input.
- A shift used without its clamp appears as 0 where 255 is expected.
- Broken stall logic appears while the consumer holds `out_ready` low. `out_data` changes, or `in_ready` stays high with both stages full, or the second sample is missing after the release.
- A correction value sampled at the wrong edge appears as the sample next to the `cfg_load` strobe coming out with the other gain.

// File: rtl/corr_pkg.sv
package corr_pkg;
  // Outcome of range check on a scaled value
  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HIGH = 2'd1,
    SAT_LOW  = 2'd2
  } sat_kind_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/corr_cfg_regs.sv
module corr_cfg_regs #(
  parameter int OFF_W   = 24,
  parameter int GAIN_W  = 16,
  parameter int SHIFT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic signed [OFF_W-1:0]  offset_in,
  input  logic [GAIN_W-1:0]        gain_in,
  input  logic [SHIFT_W-1:0]       shift_in,
  output logic signed [OFF_W-1:0]  offset_q,
  output logic [GAIN_W-1:0]        gain_q,
  output logic [SHIFT_W-1:0]       shift_q
);
  localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      gain_q   <= GAIN_UNITY;
      shift_q  <= '0;
    end else if (load) begin
      offset_q <= offset_in;
      gain_q   <= gain_in;
      shift_q  <= shift_in;
    end
  end
endmodule

// File: rtl/corr_offset_stage.sv
module corr_offset_stage #(
  parameter int RAW_W     = 24,
  parameter int OFF_W     = 24,
  parameter int GAIN_W    = 16,
  parameter int SHIFT_W   = 8,
  parameter int MAX_SHIFT = 31,
  parameter int SUM_W     = 25,
  parameter int CSH_W     = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     vin,
  input  logic signed [RAW_W-1:0]  raw,
  input  logic signed [OFF_W-1:0]  offset,
  input  logic [GAIN_W-1:0]        gain,
  input  logic [SHIFT_W-1:0]       shift,
  output logic                     vout,
  output logic signed [SUM_W-1:0]  sum_q,
  output logic [GAIN_W-1:0]        gain_q,
  output logic [CSH_W-1:0]         shift_q
);
  logic signed [SUM_W-1:0] raw_ext, off_ext, sum_d;
  logic [CSH_W-1:0]        shift_c;

  assign raw_ext = SUM_W'(raw);
  assign off_ext = SUM_W'(offset);
  assign sum_d   = raw_ext + off_ext;

  // Shift amounts past the limit collapse onto the limit
  assign shift_c = (shift > SHIFT_W'(MAX_SHIFT)) ? CSH_W'(MAX_SHIFT)
                                                 : shift[CSH_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vout <= 1'b0;
    else if (adv) vout <= vin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      gain_q  <= '0;
      shift_q <= '0;
    end else if (adv && vin) begin
      sum_q   <= sum_d;
      gain_q  <= gain;
      shift_q <= shift_c;
    end
  end
endmodule

// File: rtl/corr_saturate.sv
module corr_saturate
  import corr_pkg::*;
#(
  parameter int IN_W  = 42,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0] value,
  output sat_kind_e              kind
);
  generate
    if (IN_W > OUT_W) begin : g_check
      logic [IN_W-OUT_W:0] top_bits;
      assign top_bits = value[IN_W-1:OUT_W-1];
      always_comb begin
        if ((&top_bits) || !(|top_bits)) kind = SAT_NONE;
        else if (value[IN_W-1])          kind = SAT_LOW;
        else                             kind = SAT_HIGH;
      end
    end else begin : g_fits
      logic unused_sign;
      assign unused_sign = value[IN_W-1];
      assign kind = SAT_NONE;
    end
  endgenerate
endmodule

// File: rtl/corr_scale_stage.sv
module corr_scale_stage
  import corr_pkg::*;
#(
  parameter int SUM_W  = 25,
  parameter int GAIN_W = 16,
  parameter int CSH_W  = 5,
  parameter int PROD_W = 42,
  parameter int OUT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     vin,
  input  logic signed [SUM_W-1:0]  sum,
  input  logic [GAIN_W-1:0]        gain,
  input  logic [CSH_W-1:0]         shift,
  output logic                     vout,
  output logic signed [OUT_W-1:0]  data_q
);
  localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [PROD_W-1:0] sum_ext, gain_ext, prod, scaled;
  logic signed [OUT_W-1:0]  data_d;
  sat_kind_e                kind;

  assign sum_ext  = PROD_W'(sum);
  assign gain_ext = $signed({{(PROD_W-GAIN_W){1'b0}}, gain});
  assign prod     = sum_ext * gain_ext;
  assign scaled   = prod >>> shift;

  corr_saturate #(.IN_W(PROD_W), .OUT_W(OUT_W)) u_sat (
    .value (scaled),
    .kind  (kind)
  );

  always_comb begin
    case (kind)
      SAT_HIGH: data_d = OUT_MAX;
      SAT_LOW:  data_d = OUT_MIN;
      default:  data_d = scaled[OUT_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vout <= 1'b0;
    else if (adv) vout <= vin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (adv && vin) data_q <= data_d;
  end
endmodule

// File: rtl/offset_gain_corr.sv
module offset_gain_corr
  import corr_pkg::*;
#(
  parameter int RAW_W     = 24,
  parameter int OFF_W     = 24,
  parameter int GAIN_W    = 16,
  parameter int SHIFT_W   = 8,
  parameter int OUT_W     = 24,
  parameter int MAX_SHIFT = 31
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_load,
  input  logic signed [OFF_W-1:0]  cfg_offset,
  input  logic [GAIN_W-1:0]        cfg_gain,
  input  logic [SHIFT_W-1:0]       cfg_shift,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [RAW_W-1:0]  in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  out_data
);
  localparam int SUM_W  = max_int(RAW_W, OFF_W) + 1;
  localparam int PROD_W = SUM_W + GAIN_W + 1;
  localparam int CSH_W  = $clog2(MAX_SHIFT + 1);

  logic signed [OFF_W-1:0] off_r;
  logic [GAIN_W-1:0]       gain_r;
  logic [SHIFT_W-1:0]      shift_r;

  logic                    s1_valid, s1_adv, s2_adv;
  logic signed [SUM_W-1:0] s1_sum;
  logic [GAIN_W-1:0]       s1_gain;
  logic [CSH_W-1:0]        s1_shift;

  // Each stage moves when its successor slot is free or being drained
  assign s2_adv   = !out_valid || out_ready;
  assign s1_adv   = !s1_valid || s2_adv;
  assign in_ready = s1_adv;

  corr_cfg_regs #(.OFF_W(OFF_W), .GAIN_W(GAIN_W), .SHIFT_W(SHIFT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .offset_in (cfg_offset),
    .gain_in   (cfg_gain),
    .shift_in  (cfg_shift),
    .offset_q  (off_r),
    .gain_q    (gain_r),
    .shift_q   (shift_r)
  );

  corr_offset_stage #(
    .RAW_W(RAW_W), .OFF_W(OFF_W), .GAIN_W(GAIN_W), .SHIFT_W(SHIFT_W),
    .MAX_SHIFT(MAX_SHIFT), .SUM_W(SUM_W), .CSH_W(CSH_W)
  ) u_st1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (s1_adv),
    .vin     (in_valid),
    .raw     (in_data),
    .offset  (off_r),
    .gain    (gain_r),
    .shift   (shift_r),
    .vout    (s1_valid),
    .sum_q   (s1_sum),
    .gain_q  (s1_gain),
    .shift_q (s1_shift)
  );

  corr_scale_stage #(
    .SUM_W(SUM_W), .GAIN_W(GAIN_W), .CSH_W(CSH_W),
    .PROD_W(PROD_W), .OUT_W(OUT_W)
  ) u_st2 (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (s2_adv),
    .vin    (s1_valid),
    .sum    (s1_sum),
    .gain   (s1_gain),
    .shift  (s1_shift),
    .vout   (out_valid),
    .data_q (out_data)
  );
endmodule

// File: rtl/corr_chk.sv
module corr_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);
  // R1: reset empties the output stage
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R8: accepted sample emerges two edges later when the consumer keeps taking
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);

  // R9: a stalled output holds its value
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: an empty output stage never refuses input
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind offset_gain_corr corr_chk #(.OUT_W(OUT_W)) u_corr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/offset_gain_corr_tb.sv
module offset_gain_corr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic signed [23:0] cfg_offset = '0;
  logic [15:0] cfg_gain = '0;
  logic [7:0]  cfg_shift = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [23:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [23:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  offset_gain_corr dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_offset(cfg_offset),
    .cfg_gain(cfg_gain), .cfg_shift(cfg_shift), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  typedef struct packed {
    logic signed [23:0] raw;
    logic signed [23:0] off;
    logic [15:0]        gain;
    logic [7:0]         sh;
    logic signed [23:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{24'sd1000,    24'sd0,     16'd1,     8'd0,  24'sd1000},    // R2
    '{24'sd100,     -24'sd20,   16'd3,     8'd0,  24'sd240},     // R3
    '{-24'sd5,      24'sd0,     16'hFFFF,  8'd0,  -24'sd327675}, // R4
    '{-24'sd3,      24'sd0,     16'd1,     8'd1,  -24'sd2},      // R5
    '{24'sd7,       24'sd0,     16'd1,     8'd1,  24'sd3},       // R5
    '{24'sd8388607, 24'sd0,     16'hFFFF,  8'd40, 24'sd255},     // R6
    '{24'sd4000000, 24'sd0,     16'd4,     8'd0,  24'sd8388607}, // R7
    '{-24'sd4000000,24'sd0,     16'd4,     8'd0,  24'h800000},   // R7
    '{24'h800000,   24'h800000, 16'hFFFF,  8'd0,  24'h800000},   // R7
    '{24'sd1000,    24'sd24,    16'd5,     8'd2,  24'sd1280},    // R2
    '{-24'sd1000,   24'sd0,     16'd3,     8'd4,  -24'sd188},    // R5
    '{24'sd300,     24'sd0,     16'd0,     8'd0,  24'sd0}        // R4
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 9:     return "R2";
      1:        return "R3";
      2, 11:    return "R4";
      3, 4, 10: return "R5";
      5:        return "R6";
      default:  return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic signed [31:0] act,
                     input logic signed [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input logic signed [23:0] o, input logic [15:0] g,
                          input logic [7:0] s);
    cfg_load = 1'b1; cfg_offset = o; cfg_gain = g; cfg_shift = s;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Called at a negedge; returns at the negedge where the result is visible
  task automatic run_one(input logic signed [23:0] raw,
                         input logic signed [23:0] exp, input string tag);
    in_valid = 1'b1; in_data = raw;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R8", 32'(out_valid), 32'd1);
    chk(tag, 32'(out_data), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 32'(out_valid), 32'd0);
    chk("R1", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default registers pass samples unchanged
    run_one(24'sd12345, 24'sd12345, "R1");
    run_one(-24'sd77, -24'sd77, "R1");

    for (int i = 0; i < NV; i++) begin
      load_cfg(VECS[i].off, VECS[i].gain, VECS[i].sh);
      run_one(VECS[i].raw, VECS[i].exp, tag_of(i));
    end

    // R9: back-pressure with pass-through settings
    load_cfg(24'sd0, 16'd1, 8'd0);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 24'sd11;
    @(negedge clk);
    in_data = 24'sd22;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", 32'(out_valid), 32'd1);
    chk("R9", 32'(in_ready), 32'd0);
    chk("R9", 32'(out_data), 32'sd11);
    repeat (3) @(negedge clk);
    chk("R9", 32'(out_data), 32'sd11);
    chk("R9", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9", 32'(out_valid), 32'd1);
    chk("R9", 32'(out_data), 32'sd22);
    @(negedge clk);
    chk("R9", 32'(out_valid), 32'd0);

    // R10: sample accepted with the load strobe uses the old gain
    in_valid = 1'b1; in_data = 24'sd10;
    cfg_load = 1'b1; cfg_offset = 24'sd0; cfg_gain = 16'd2; cfg_shift = 8'd0;
    @(negedge clk);
    cfg_load = 1'b0;
    in_data = 24'sd10;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", 32'(out_data), 32'sd10);
    @(negedge clk);
    chk("R10", 32'(out_valid), 32'd1);
    chk("R10", 32'(out_data), 32'sd20);
    @(negedge clk);

    // R1: a second reset restores pass-through
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_one(24'sd4321, 24'sd4321, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule